// File: doc/BRIEF.md
# Masked Four-Column Block-Write Unit

This unit is the write path of a multiport video memory core. In a single write it fills a block of four adjacent columns in one row with the contents of a 4-bit color register. Two masks act together. A column mask, taken from the data pins when the column strobe falls, picks which of the four columns change. A plane mask picks which of the four bit planes change in those columns.

The plane mask has three variants, chosen by the write-enable and special-function inputs when the row strobe falls. The write mask can be loaded fresh from the data pins and used at once, or the stored mask can be reused, or masking can be switched off so that all planes are written. The strobes are active-low inputs sampled on the system clock, and their falling edges are found by comparing each strobe with its value one cycle earlier. A read port gives combinational access to any cell of the internal array.

Top module: `block_write_unit`

## Requirements
- R1: After reset every array cell reads 0, the color register holds 0 and the stored write mask is all ones.
- R2: A block write uses column address bits COL_W-1 down to 2 as the block number, which selects columns 4*block through 4*block+3. Column address bits 1 and 0 have no effect on which cells are written.
- R3: During a block write, bit n of the data pins at the column-strobe fall is the column mask for column 4*block+n. A 1 writes that column and a 0 leaves it unchanged.
- R4: A plane-mask bit of 1 lets bit plane n take the color bit n. A 0 keeps the old value of plane n in every selected column.
- R5: If we_n=0 and dsf=0 when the row strobe falls, the data pins are stored as the new write mask, and the block write in that row cycle uses it.
- R6: If we_n=1 and dsf=0 when the row strobe falls, the stored write mask is used unchanged and the data pins are ignored. Before any mask has been loaded, this acts as an unmasked write.
- R7: If dsf=1 when the row strobe falls, all planes are written whatever the value of we_n, and the stored write mask is kept for later cycles.
- R8: The written data comes from the color register. That register loads color_in only on a cycle with color_ld=1.
- R9: A block write happens only when the column strobe falls while the row strobe has been low for at least one cycle and dsf=1. If dsf=0 at that fall, no cell changes.
- R10: The row is taken from addr[ROW_W-1:0] when the row strobe falls. Changes on addr later in the row cycle do not change the row.
- R11: A block write becomes visible on the read port in the clock cycle after the edge at which the column-strobe fall is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, sampled at row-strobe fall to select the mask variant |
| dsf | input | 1 | Special-function select: mask variant at row fall, block-write flag at column fall |
| addr | input | ADDR_W | Row address at row fall, column address at column fall |
| dq | input | 4 | Write mask at row fall, column mask at column fall |
| color_ld | input | 1 | Loads color_in into the color register |
| color_in | input | 4 | New color value |
| rd_row | input | ROW_W | Read-port row |
| rd_col | input | COL_W | Read-port column |
| rd_data | output | 4 | Contents of the addressed cell |

## Verification
The bench builds the unit with its default values: four rows of thirty-two columns, which gives eight blocks per row and a five-bit address bus. At this size the bench can compare the whole array against its model after every stimulus. That catches a write that lands in the wrong row or block as surely as a wrong bit in the target block. The small row count still lets the address pins carry a different column address than the row address, so the row-latch rule is exercised in every cycle.

// File: rtl/block_write_unit.sv
module block_write_unit #(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 5,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              dsf,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        dq,
  input  logic              color_ld,
  input  logic [3:0]        color_in,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [COL_W-1:0]  rd_col,
  output logic [3:0]        rd_data
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int CELLS = 1 << IDX_W;

  logic             ras_q, cas_q, mask_off_q;
  logic [ROW_W-1:0] row_q;
  logic [3:0]       wmask_q, color_q, pmask;
  logic [3:0]       mem [CELLS];
  logic             ras_fall, blk_fire;

  assign ras_fall = ras_q & ~ras_n;
  assign blk_fire = cas_q & ~cas_n & ~ras_q & ~ras_n & dsf;
  assign pmask    = mask_off_q ? 4'hF : wmask_q;
  assign rd_data  = mem[{rd_row, rd_col}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q      <= 1'b1;
      cas_q      <= 1'b1;
      row_q      <= '0;
      mask_off_q <= 1'b0;
      wmask_q    <= 4'hF;
      color_q    <= 4'h0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (color_ld) color_q <= color_in;
      if (ras_fall) begin
        row_q      <= addr[ROW_W-1:0];
        mask_off_q <= dsf;
        if (!we_n && !dsf) wmask_q <= dq;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) mem[i] <= 4'h0;
    end else if (blk_fire) begin
      for (int c = 0; c < 4; c++) begin
        if (dq[c]) begin
          mem[{row_q, addr[COL_W-1:2], 2'(c)}] <=
            (mem[{row_q, addr[COL_W-1:2], 2'(c)}] & ~pmask) | (color_q & pmask);
        end
      end
    end
  end

  assert_wmask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n && !we_n && !dsf) |=> (wmask_q == $past(dq)));

  assert_wmask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_q && !ras_n && !we_n && !dsf) |=> $stable(wmask_q));

  assert_color_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !color_ld |=> $stable(color_q));

  assert_row_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n) |=> (row_q == $past(addr[ROW_W-1:0])));

  assert_row_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_q && !ras_n) |=> ($stable(row_q) && $stable(mask_off_q)));
endmodule

// File: tb/test_block_write_unit.sv
`timescale 1ns/1ps
module test_block_write_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
  logic [4:0] addr = '0;
  logic [3:0] dq = '0;
  logic       color_ld = 1'b0;
  logic [3:0] color_in = '0;
  logic [1:0] rd_row = '0;
  logic [4:0] rd_col = '0;
  logic [3:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [3:0] mdl [4][32];
  logic [3:0] m_wmask = 4'hF;
  logic [3:0] m_color = 4'h0;

  always #10 clk = ~clk;

  block_write_unit i_block_write_unit (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dsf(dsf), .addr(addr), .dq(dq), .color_ld(color_ld), .color_in(color_in),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data));

  // {we_n, dsf at row fall, dq at row fall, row, column address, column mask, color}
  localparam logic [20:0] VEC [10] = '{
    {1'b1, 1'b0, 4'h0, 2'd0, 5'd0,  4'hF, 4'hA},  // R6 reuse of reset mask
    {1'b1, 1'b0, 4'h6, 2'd1, 5'd7,  4'b1010, 4'h5},  // R2 low bits ignored
    {1'b0, 1'b0, 4'h3, 2'd2, 5'd9,  4'hF, 4'hC},  // R5 load and use
    {1'b1, 1'b0, 4'h0, 2'd2, 5'd9,  4'b0110, 4'h0},  // R6 reuse loaded
    {1'b0, 1'b1, 4'h0, 2'd3, 5'd31, 4'b1001, 4'hF},  // R7 mask disabled
    {1'b1, 1'b0, 4'h0, 2'd3, 5'd31, 4'b0110, 4'h0},  // R7 stored mask kept
    {1'b0, 1'b0, 4'h0, 2'd1, 5'd4,  4'hF, 4'hF},  // R4 all planes protected
    {1'b1, 1'b1, 4'h5, 2'd0, 5'd2,  4'b0011, 4'h6},  // R7 both controls high
    {1'b0, 1'b0, 4'h9, 2'd0, 5'd3,  4'hF, 4'h6},  // R4 partial plane mask
    {1'b1, 1'b0, 4'h0, 2'd1, 5'd28, 4'b1000, 4'hE}   // R3 single column
  };

  task automatic cycle_blk(input logic wv, input logic dr, input logic [3:0] wm,
                           input logic [1:0] row, input logic [4:0] ca,
                           input logic [3:0] cm, input logic [3:0] col,
                           input logic bf, input logic ldc);
    logic [3:0] pm;
    @(negedge clk);
    color_in = col; color_ld = ldc;
    @(negedge clk);
    color_ld = 1'b0;
    color_in = ~col;
    ras_n = 1'b0; we_n = wv; dsf = dr; dq = wm; addr = {3'b110, row};
    @(negedge clk);
    cas_n = 1'b0; we_n = 1'b0; dsf = bf; dq = cm; addr = ca;
    @(negedge clk);
    cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; dsf = 1'b0; dq = 4'h0; addr = 5'h15;
    if (ldc) m_color = col;
    if (!wv && !dr) m_wmask = wm;
    pm = dr ? 4'hF : m_wmask;
    if (bf)
      for (int c = 0; c < 4; c++)
        if (cm[c]) mdl[row][{ca[4:2], 2'(c)}] = (mdl[row][{ca[4:2], 2'(c)}] & ~pm) | (m_color & pm);
  endtask

  task automatic read_cell(input logic [1:0] r, input logic [4:0] c, output logic [3:0] v);
    rd_row = r; rd_col = c;
    #1 v = rd_data;
  endtask

  task automatic check_block(input logic [1:0] r, input logic [4:0] ca, input string tag);
    logic [15:0] act, exp;
    logic [3:0] v;
    for (int c = 0; c < 4; c++) begin
      read_cell(r, {ca[4:2], 2'(c)}, v);
      act[c*4 +: 4] = v;
      exp[c*4 +: 4] = mdl[r][{ca[4:2], 2'(c)}];
    end
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s block row %0d col %0d: actual %h expected %h", tag, r, ca, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int bad = 0;
    logic [3:0] v;
    logic [3:0] fa = '0, fe = '0;
    int fr = 0, fc = 0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 32; c++) begin
        read_cell(2'(r), 5'(c), v);
        if (v !== mdl[r][c]) begin
          if (bad == 0) begin fa = v; fe = mdl[r][c]; fr = r; fc = c; end
          bad++;
        end
      end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s array row %0d col %0d: actual %h expected %h (%0d cells differ)",
               tag, fr, fc, fa, fe, bad);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] v;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 32; c++) mdl[r][c] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset array");

    for (int i = 0; i < 10; i++) begin
      cycle_blk(VEC[i][20], VEC[i][19], VEC[i][18:15], VEC[i][14:13], VEC[i][12:8],
                VEC[i][7:4], VEC[i][3:0], 1'b1, 1'b1);
      check_block(VEC[i][14:13], VEC[i][12:8], "R3/R4 target block");
      check_all("R2/R10 whole array");
    end

    // R11: result visible in the cycle after the sampled column fall
    @(negedge clk);
    color_in = 4'h7; color_ld = 1'b1;
    @(negedge clk);
    color_ld = 1'b0;
    ras_n = 1'b0; we_n = 1'b1; dsf = 1'b1; addr = 5'd2;
    @(negedge clk);
    cas_n = 1'b0; dsf = 1'b1; dq = 4'b0001; addr = 5'd20;
    read_cell(2'd2, 5'd20, v);
    checks++;
    if (v !== mdl[2][20]) begin
      errors++;
      $display("FAIL R11 before edge: actual %h expected %h", v, mdl[2][20]);
    end
    @(negedge clk);
    cas_n = 1'b1; ras_n = 1'b1; dsf = 1'b0; dq = 4'h0;
    m_color = 4'h7;
    mdl[2][20] = (mdl[2][20] & ~4'hF) | 4'h7;
    read_cell(2'd2, 5'd20, v);
    checks++;
    if (v !== 4'h7) begin
      errors++;
      $display("FAIL R11 after edge: actual %h expected %h", v, 4'h7);
    end

    // R9: dsf low at column fall writes nothing
    cycle_blk(1'b1, 1'b1, 4'h0, 2'd3, 5'd12, 4'hF, 4'h9, 1'b0, 1'b1);
    check_all("R9 no block flag");

    // R8: color_in changes without color_ld are ignored
    cycle_blk(1'b1, 1'b1, 4'h0, 2'd3, 5'd12, 4'b0101, 4'h2, 1'b1, 1'b0);
    check_block(2'd3, 5'd12, "R8 color held");

    // R5 then R6: new mask loaded and reused in the next row cycle
    cycle_blk(1'b0, 1'b0, 4'hC, 2'd0, 5'd16, 4'hF, 4'hF, 1'b1, 1'b1);
    check_block(2'd0, 5'd16, "R5 load mask C");
    cycle_blk(1'b1, 1'b0, 4'h3, 2'd0, 5'd17, 4'hF, 4'h0, 1'b1, 1'b1);
    check_block(2'd0, 5'd17, "R6 reuse mask C");
    check_all("R2/R3 final array");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule